// File: doc/BRIEF.md
# Three-Level Virtual Address Translator

This block turns a virtual address into a physical address by walking a page table of three levels held in memory. A caller presents a virtual address, an access kind (load, store or instruction fetch) and a privilege flag. The block then reads one 64-bit table entry per level through a simple valid/ready memory port, starting from the table page named on a translation-base input. It ends the walk with one response that carries either a 56-bit physical address or a fault with its cause.

Only one translation is in flight at a time. The upper part of the virtual address is disregarded. Each level of the table is one 4096-byte page of 512 entries. An entry holds a 44-bit page number in bits 53:10 and flags in its low bits: valid in bit 0, read in bit 1, write in bit 2, execute in bit 3 and user in bit 4. An entry with both read and execute clear is a pointer to the next level. Large pages are not supported, so a leaf found above the last level is a fault.

Top module: `sv39_walker`

## Requirements
- R1: After a synchronous reset, `busy`, `rsp_valid` and `mem_req_valid` are 0 and `req_ready` is 1.
- R2: The walk reads the root entry, then the middle entry, then the final entry. Each read address is (table page number << 12) + index * 8. The root table page comes from `root_ppn`. The indices are vaddr[38:30] for the root, vaddr[29:21] for the middle level and vaddr[20:12] for the final level. The next table page is entry bits 53:10.
- R3: vaddr bits 63:39 have no effect on the read addresses or on the response.
- R4: An entry at any level with bit 0 (valid) clear ends the walk with `rsp_fault`=1 and `rsp_cause`=1, and no further entries are read.
- R5: A valid final-level entry with bit 1 (R) and bit 3 (X) both clear, or a valid root or middle entry with R or X set, ends the walk with `rsp_fault`=1 and `rsp_cause`=2.
- R6: For a valid final leaf, access code 0 (load) needs R, code 1 (store) needs W (bit 2) and code 2 (fetch) needs X. Code 3 is always refused. With `req_user`=1 the entry also needs U (bit 4). With `req_user`=0, U is not consulted. A refusal gives `rsp_fault`=1 and `rsp_cause`=3.
- R7: A permitted access responds with `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = {final entry bits 53:10, vaddr[11:0]}.
- R8: A request is taken only when `req_ready`=1. From the cycle after it is taken until its response, `busy`=1 and `req_ready`=0, and any request presented in that window is ignored.
- R9: Each walk gives exactly one `rsp_valid` pulse, one cycle long. It comes on the cycle after the edge at which the memory response holding the deciding entry is taken.
- R10: `mem_req_valid` stays high with a stable, 8-byte-aligned `mem_req_addr` until `mem_req_ready`. A response is taken only after the matching request has been accepted, and each read returns one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 64 | Virtual address (bits 38:0 used) |
| req_acc | input | 2 | 0 load, 1 store, 2 fetch, 3 refused |
| req_user | input | 1 | 1 user privilege, 0 supervisor |
| root_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 64 | Entry data |
| busy | output | 1 | Walk in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 bad shape, 3 permission |
| rsp_paddr | output | 56 | Physical address on success, else 0 |

## Verification
The first read request appears the cycle after the request is taken. Each later read appears the cycle after the previous entry is taken. The response is registered, so it is due exactly one cycle after the edge that takes the deciding entry. The bench's memory model records the cycle at which it drives that entry and checks that the response pulse lands on the following cycle and lasts only that cycle, while random ready and latency stalls move the due cycle from walk to walk. Outputs are sampled on the falling edge, between the edges that change them.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_INVAL = 2'd1,
    FLT_SHAPE = 2'd2,
    FLT_PERM  = 2'd3
  } cause_e;

  localparam int FB_V = 0;
  localparam int FB_R = 1;
  localparam int FB_W = 2;
  localparam int FB_X = 3;
  localparam int FB_U = 4;
endpackage

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
  parameter int VA_W   = 39,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] slice [LEVELS];

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
      assign slice[g] = va[OFF_W + g*IDX_W +: IDX_W];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (lvl == LVL_W'(i)) idx = slice[i];
    end
  end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int PA_W  = 56,
  parameter int PPN_W = 44,
  parameter int OFF_W = 12,
  parameter int IDX_W = 9,
  parameter int PTE_W = 64,
  localparam int ESH  = $clog2(PTE_W/8)
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] base;
  logic [PA_W-1:0] ofs;

  assign base = {ppn, {OFF_W{1'b0}}};
  assign ofs  = PA_W'(idx) << ESH;
  assign addr = base + ofs;
endmodule

// File: rtl/pw_pte_eval.sv
module pw_pte_eval
  import pw_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int PPN_W  = 44,
  parameter int FLAG_W = 10
) (
  input  logic [PTE_W-1:0] pte,
  input  logic             last_lvl,
  input  logic [1:0]       acc,
  input  logic             user,
  output logic [PPN_W-1:0] next_ppn,
  output logic             invalid,
  output logic             shape_bad,
  output logic             descend,
  output logic             perm_bad
);
  logic v, r, w, x, u, leaf, acc_ok;

  assign v = pte[FB_V];
  assign r = pte[FB_R];
  assign w = pte[FB_W];
  assign x = pte[FB_X];
  assign u = pte[FB_U];
  assign leaf     = r | x;
  assign next_ppn = pte[FLAG_W +: PPN_W];

  always_comb begin
    unique case (acc_e'(acc))
      ACC_LOAD:  acc_ok = r;
      ACC_STORE: acc_ok = w;
      ACC_FETCH: acc_ok = x;
      default:   acc_ok = 1'b0;
    endcase
  end

  assign invalid   = !v;
  assign shape_bad = v && (leaf ? !last_lvl : last_lvl);
  assign descend   = v && !leaf && !last_lvl;
  assign perm_bad  = !acc_ok || (user && !u);
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
  import pw_pkg::*;
#(
  parameter int VIN_W  = 64,
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int PPN_W  = 44,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 3,
  parameter int PTE_W  = 64,
  parameter int FLAG_W = 10,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VIN_W-1:0] req_vaddr,
  input  logic [1:0]       req_acc,
  input  logic             req_user,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             busy,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_e;

  st_e              st;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] cur_ppn;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q;
  logic             fault_q;
  logic [1:0]       cause_q;
  logic [PA_W-1:0]  paddr_q;

  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  ent_addr;
  logic [PPN_W-1:0] nxt_ppn;
  logic             e_inval, e_shape, e_desc, e_perm;
  logic             take_req, take_rsp;

  pw_index_sel #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)) u_idx (
    .va(va_q), .lvl(lvl), .idx(idx)
  );

  pw_addr_gen #(.PA_W(PA_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .PTE_W(PTE_W)) u_addr (
    .ppn(cur_ppn), .idx(idx), .addr(ent_addr)
  );

  pw_pte_eval #(.PTE_W(PTE_W), .PPN_W(PPN_W), .FLAG_W(FLAG_W)) u_eval (
    .pte(mem_rsp_data), .last_lvl(lvl == '0), .acc(acc_q), .user(user_q),
    .next_ppn(nxt_ppn), .invalid(e_inval), .shape_bad(e_shape),
    .descend(e_desc), .perm_bad(e_perm)
  );

  assign take_req = (st == S_IDLE) && req_valid;
  assign take_rsp = (st == S_WAIT) && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      lvl     <= '0;
      cur_ppn <= '0;
      va_q    <= '0;
      acc_q   <= '0;
      user_q  <= 1'b0;
      fault_q <= 1'b0;
      cause_q <= FLT_NONE;
      paddr_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (take_req) begin
          st      <= S_ISSUE;
          lvl     <= LVL_W'(LEVELS-1);
          cur_ppn <= root_ppn;
          va_q    <= req_vaddr[VA_W-1:0];
          acc_q   <= req_acc;
          user_q  <= req_user;
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (take_rsp) begin
          if (e_desc) begin
            st      <= S_ISSUE;
            lvl     <= lvl - 1'b1;
            cur_ppn <= nxt_ppn;
          end else begin
            st      <= S_RESP;
            fault_q <= e_inval || e_shape || e_perm;
            paddr_q <= '0;
            if (e_inval)      cause_q <= FLT_INVAL;
            else if (e_shape) cause_q <= FLT_SHAPE;
            else if (e_perm)  cause_q <= FLT_PERM;
            else begin
              cause_q <= FLT_NONE;
              paddr_q <= {nxt_ppn, va_q[OFF_W-1:0]};
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_ISSUE);
  assign mem_req_addr  = ent_addr;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_cause     = cause_q;
  assign rsp_paddr     = paddr_q;

  // R1: reset leaves the walker idle
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (req_ready && !busy && !rsp_valid && !mem_req_valid));
  // R8: a taken request makes the walker busy
  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> busy);
  // R9: the response pulse is one cycle long
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid);
  // R9: a response follows a taken memory entry
  a_r9_rsp_after_entry: assert property (@(posedge clk) disable iff (rst) $rose(rsp_valid) |-> $past(mem_rsp_valid));
  // R10: a stalled read holds its address
  a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R10: entry addresses are aligned
  a_r10_aligned: assert property (@(posedge clk) disable iff (rst) mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
  // R7: a success carries cause 0, a fault carries a nonzero cause
  a_r7_cause_match: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));
endmodule

// File: tb/tb_sv39_walker.sv
module tb_sv39_walker;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 0;
  logic [43:0] root_ppn = 44'd1;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic        busy, rsp_valid, rsp_fault;
  logic [1:0]  rsp_cause;
  logic [55:0] rsp_paddr;

  always #10 clk = ~clk;

  sv39_walker dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user), .root_ppn(root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: 8 pages of 512 entries
  logic [63:0] mem [0:4095];
  logic [55:0] exp_addr [3];
  int          nreads = 0;
  bit          pend = 0;
  int          dly = 0;
  logic [55:0] pend_addr = '0;
  int          last_rsp_cyc = -10;
  bit          prev_rsp = 0;
  bit          prev_stall = 0;
  logic [55:0] prev_addr = '0;

  function automatic logic [63:0] mkpte(logic [43:0] ppn, logic [9:0] fl);
    return {10'b0, ppn, fl};
  endfunction

  function automatic logic [63:0] rdmem(logic [55:0] a);
    if (a[55:15] != 0) return 64'd0;
    return mem[a[14:3]];
  endfunction

  function automatic logic [43:0] fin_ppn(int i);
    return 44'hF00_0000_0000 + 44'(i) * 44'h1001;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (rsp_valid) chk("R9 response cycle", 64'(cyc), 64'(last_rsp_cyc + 1));
      if (rsp_valid && prev_rsp) chk("R9 pulse width", 64'd2, 64'd1);
      prev_rsp = rsp_valid;
      if (prev_stall) begin
        chk("R10 held valid", 64'(mem_req_valid), 64'd1);
        chk("R10 held addr", 64'(mem_req_addr), 64'(prev_addr));
      end
      mem_rsp_valid = 0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1;
          mem_rsp_data = rdmem(pend_addr);
          pend = 0;
          last_rsp_cyc = cyc;
        end else dly--;
      end
      mem_req_ready = ($urandom % 3) != 0;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready && !pend && !mem_rsp_valid) begin
        if (nreads < 3) chk($sformatf("R2 read %0d addr", nreads), 64'(mem_req_addr), 64'(exp_addr[nreads]));
        nreads++;
        pend = 1;
        dly = $urandom % 3;
        pend_addr = mem_req_addr;
      end else if (mem_req_valid && mem_req_ready) begin
        mem_req_ready = 0;
        prev_stall = 1;
      end
    end
  end

  function automatic logic [63:0] mkva(int v2, int v1, int v0, logic [11:0] off, logic [24:0] hi);
    return {hi, 9'(v2), 9'(v1), 9'(v0), off};
  endfunction

  logic [55:0] got_pa;

  task automatic walk(string tag, logic [63:0] va, logic [1:0] acc, bit usr,
                      bit ef, logic [1:0] ec, logic [55:0] epa, int nexp, bit interfere);
    int t;
    exp_addr[0] = (56'd1 << 12) + 56'(va[38:30]) * 8;
    exp_addr[1] = (56'd2 << 12) + 56'(va[29:21]) * 8;
    exp_addr[2] = (56'd3 << 12) + 56'(va[20:12]) * 8;
    nreads = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc; req_user = usr;
    @(negedge clk);
    chk({tag, " R8 busy"}, 64'(busy), 64'd1);
    chk({tag, " R8 ready low"}, 64'(req_ready), 64'd0);
    req_valid = interfere;
    req_vaddr = ~va; req_acc = ~acc; req_user = ~usr;
    t = 0;
    while (!rsp_valid && t < 300) begin @(negedge clk); t++; end
    if (t >= 300) chk({tag, " watchdog"}, 64'd1, 64'd0);
    req_valid = 0;
    chk({tag, " fault"}, 64'(rsp_fault), 64'(ef));
    chk({tag, " cause"}, 64'(rsp_cause), 64'(ec));
    if (!ef) chk({tag, " R7 paddr"}, 64'(rsp_paddr), 64'(epa));
    got_pa = rsp_paddr;
    chk({tag, " read count"}, 64'(nreads), 64'(nexp));
  endtask

  initial begin
    logic [55:0] pa0;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[512 + 0] = mkpte(44'd2, 10'h001);
    mem[512 + 1] = mkpte(44'd2, 10'h01E);
    mem[512 + 2] = mkpte(44'd5, 10'h01F);
    mem[512 + 3] = mkpte(44'd2, 10'h001);
    mem[1024 + 0] = mkpte(44'd3, 10'h001);
    mem[1024 + 1] = mkpte(44'd3, 10'h002);
    mem[1024 + 2] = mkpte(44'd6, 10'h00B);
    for (int i = 0; i < 32; i++) mem[1536 + i] = mkpte(fin_ppn(i), 10'(i));

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);

    // R4/R5/R6/R7: sweep every final-leaf flag combination, access and privilege
    for (int i = 0; i < 32; i++) begin
      for (int a = 0; a < 4; a++) begin
        for (int u = 0; u < 2; u++) begin
          logic [63:0] va;
          logic [1:0] c;
          bit ok;
          va = mkva((i % 2) ? 3 : 0, 0, i, 12'(i * 37 + a * 5 + 3), 25'(i * 24'h13579B));
          ok = (a == 0) ? i[1] : (a == 1) ? i[2] : (a == 2) ? i[3] : 1'b0;
          if (!i[0]) c = 2'd1;
          else if (!i[1] && !i[3]) c = 2'd2;
          else if ((u == 1 && !i[4]) || !ok) c = 2'd3;
          else c = 2'd0;
          walk($sformatf("R6 sweep f=%0h a=%0d u=%0d", i, a, u), va, 2'(a), u[0],
               c != 0, c, {fin_ppn(i), va[11:0]}, 3, 0);
        end
      end
    end

    // R4: invalid root entry, stops after one read
    walk("R4 root invalid", mkva(1, 0, 31, 12'h10, 25'd0), 2'd0, 0, 1, 2'd1, '0, 1, 0);
    walk("R4 root empty", mkva(300, 0, 31, 12'h10, 25'd0), 2'd0, 0, 1, 2'd1, '0, 1, 0);
    walk("R4 middle invalid", mkva(0, 1, 31, 12'h10, 25'd0), 2'd0, 0, 1, 2'd1, '0, 2, 0);
    // R5: leaf above the final level
    walk("R5 root leaf", mkva(2, 0, 31, 12'h10, 25'd0), 2'd0, 0, 1, 2'd2, '0, 1, 0);
    walk("R5 middle leaf", mkva(0, 2, 31, 12'h10, 25'd0), 2'd2, 0, 1, 2'd2, '0, 2, 0);

    // R3: upper bits do not change the result
    walk("R3 hi zero", mkva(0, 0, 31, 12'hABC, 25'd0), 2'd1, 1, 0, 2'd0, {fin_ppn(31), 12'hABC}, 3, 0);
    pa0 = got_pa;
    walk("R3 hi ones", mkva(0, 0, 31, 12'hABC, 25'h1FFFFFF), 2'd1, 1, 0, 2'd0, {fin_ppn(31), 12'hABC}, 3, 0);
    chk("R3 same paddr", 64'(got_pa), 64'(pa0));

    // R8: requests while busy are ignored
    walk("R8 interfere ok", mkva(3, 0, 27, 12'h5A5, 25'h0F0F0F), 2'd2, 1, 0, 2'd0, {fin_ppn(27), 12'h5A5}, 3, 1);
    walk("R8 interfere fault", mkva(0, 0, 3, 12'h001, 25'd7), 2'd1, 0, 1, 2'd3, '0, 3, 1);
    repeat (4) @(negedge clk);
    chk("R8 idle after ignored", 64'(busy), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule